// File: doc/BRIEF.md
# Panel Display Controller Register and Interrupt Unit

This block is the software-visible face of a panel display controller. It decodes a simple 32-bit bus with a byte offset. It holds a control word, three timing words, a read-only status word and a sub-panel word. It also exports the decoded configuration (active size, panel type, palette-load mode, sub-panel placement) to the fetch and timing engines beside it.

The frame sequencer reports three conditions as single-cycle pulses: frame finished, palette loaded and sync error. The block keeps each as a sticky status flag and drives one level interrupt from them. Turning the controller on or off through the enable bit changes these flags as a side effect, so software sees a consistent status after a mode change.

Reads are combinational: `bus_rdata` carries the addressed word in the same cycle that `bus_rd` is high, and is zero otherwise. Several read values carry fixed one bits that no write can remove.

Top module: `lcd_reg_block`

## Requirements
- R1: After reset every stored field and flag is zero. Reads then return 0xfe000c34 for control, 0x0000000f for timing 0, 0xfc000000 for timing 2, and zero for timing 1, status and sub-panel. The interrupt is low and every exported field is zero.
- R2: A control write at offset 0x00 stores these fields: enable from bit 0, mono from bit 1, the two interrupt enables from bits 4:3, panel type from bit 7 and palette-load mode from bits 21:20. The other written bits are kept only where mask 0x01cff300 is one. A read returns the stored bits with the panel-type bit also placed at bit 23, ORed with 0xfe000c34.
- R3: A write at offset 0x04 stores width minus one from bits 9:0 and bits 31:10 unchanged. A read returns the written word with bits 3:0 forced to one.
- R4: Offset 0x08 stores the whole word and reads it back unchanged, with height minus one in bits 9:0. Offset 0x0c stores the whole word and reads it back ORed with 0xfc000000.
- R5: Offset 0x10 is read-only, and a write there leaves every status flag unchanged.
- R6: Data written at offset 0x14 is stored ANDed with 0xa1ffffff and read back as stored.
- R7: The status read holds frame-done at bit 0, sync-error at bit 2 and palette-loaded at bit 6. Each flag is set in the cycle after its event pulse and stays set until an enable transition clears it. When an event pulse and a clearing transition fall in the same cycle, the event wins.
- R8: `lcd_irq` is high exactly when frame-done is set with interrupt enable bit 3, or palette-loaded is set with interrupt enable bit 4, or sync-error is set regardless of the enables.
- R9: A control write that turns enable from 1 to 0 clears sync-error. It also sets frame-done unless the newly written palette-load mode is 1.
- R10: A control write that turns enable from 0 to 1 while `seq_idle` is high clears frame-done and palette-loaded. With `seq_idle` low, these flags keep their values.
- R11: A read at any offset other than 0x00, 0x04, 0x08, 0x0c, 0x10 or 0x14 returns zero and raises `bad_access` for exactly the next cycle. A write at such an offset changes no register.
- R12: The outputs `cfg_enable`, `cfg_mono`, `cfg_active_matrix` and `cfg_load_mode` follow the stored control fields. `cfg_width_m1` follows timing 0 bits 9:0 and `cfg_height_m1` follows timing 1 bits 9:0. `cfg_sub_enable`, `cfg_sub_lower` and `cfg_sub_line` follow sub-panel bits 31, 29 and 25:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| bad_access | output | 1 | One-cycle pulse after an unmapped read |
| ev_frame_done | input | 1 | Frame-finished pulse from the sequencer |
| ev_palette_done | input | 1 | Palette-loaded pulse from the sequencer |
| ev_sync_err | input | 1 | Sync-error pulse from the sequencer |
| seq_idle | input | 1 | Sequencer has no frame in progress |
| lcd_irq | output | 1 | Level interrupt |
| cfg_enable | output | 1 | Controller enable |
| cfg_mono | output | 1 | Monochrome panel |
| cfg_active_matrix | output | 1 | Active-matrix panel type |
| cfg_load_mode | output | 2 | Palette-load mode |
| cfg_width_m1 | output | DIM_W | Active width minus one |
| cfg_height_m1 | output | DIM_W | Active height minus one |
| cfg_sub_enable | output | 1 | Sub-panel mode on |
| cfg_sub_lower | output | 1 | Sub-panel line selects the start row |
| cfg_sub_line | output | DIM_W | Sub-panel line number |

## Verification
The hardest situations to reach are the enable transitions that collide with other effects. One case is a disable write that lands in the same cycle as a sync-error pulse. Another is an enable write made while the sequencer is busy. A third is a disable with palette-load mode 1 written in the same word. Directed sequences first set up a known flag pattern through event pulses. They then issue the colliding write and read status back. A long random phase mixes writes, reads, all three event pulses and the idle input every cycle, against a behavioural model that is compared on every clock.

// File: rtl/lcd_reg_pkg.sv
package lcd_reg_pkg;

    localparam int DATA_W   = 32;
    localparam int NUM_REGS = 6;

    // register order equals offset / 4
    typedef enum logic [2:0] {
        SEL_CTRL = 3'd0,
        SEL_TIM0 = 3'd1,
        SEL_TIM1 = 3'd2,
        SEL_TIM2 = 3'd3,
        SEL_STAT = 3'd4,
        SEL_SUB  = 3'd5,
        SEL_NONE = 3'd7
    } reg_sel_e;

    localparam logic [DATA_W-1:0] CTRL_KEEP_MASK = 32'h01cff300;
    localparam logic [DATA_W-1:0] CTRL_RD_ONES   = 32'hfe000c34;
    localparam logic [DATA_W-1:0] TIM0_RD_ONES   = 32'h0000000f;
    localparam logic [DATA_W-1:0] TIM2_RD_ONES   = 32'hfc000000;
    localparam logic [DATA_W-1:0] SUB_KEEP_MASK  = 32'ha1ffffff;

    localparam int STAT_FD_BIT = 0;
    localparam int STAT_SE_BIT = 2;
    localparam int STAT_PL_BIT = 6;

    localparam int SUB_EN_BIT    = 31;
    localparam int SUB_LOWER_BIT = 29;
    localparam int SUB_LINE_LSB  = 16;

    localparam logic [1:0] LOAD_PALETTE_ONLY = 2'd1;

    typedef struct packed {
        logic [DATA_W-1:0] misc;
        logic [1:0]        load_mode;
        logic              active_matrix;
        logic [1:0]        irq_en;
        logic              mono;
        logic              enable;
    } ctrl_t;

    typedef struct packed {
        logic frame_done;
        logic palette_done;
        logic sync_err;
    } flags_t;

    function automatic ctrl_t ctrl_unpack(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.misc          = w & CTRL_KEEP_MASK;
        c.load_mode     = w[21:20];
        c.active_matrix = w[7];
        c.irq_en        = w[4:3];
        c.mono          = w[1];
        c.enable        = w[0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_pack(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w        = c.misc;
        w[0]     = w[0] | c.enable;
        w[1]     = w[1] | c.mono;
        w[4:3]   = w[4:3] | c.irq_en;
        w[7]     = w[7] | c.active_matrix;
        w[21:20] = w[21:20] | c.load_mode;
        w[23]    = w[23] | c.active_matrix;
        return w;
    endfunction

endpackage

// File: rtl/lcd_addr_decode.sv
module lcd_addr_decode
    import lcd_reg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    always_comb begin
        sel = SEL_NONE;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (addr == ADDR_W'(i * 4))
                sel = reg_sel_e'(3'(i));
        end
    end
endmodule

// File: rtl/lcd_status_flags.sv
module lcd_status_flags
    import lcd_reg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ev_frame_done,
    input  logic       ev_palette_done,
    input  logic       ev_sync_err,
    input  logic       en_fall,
    input  logic       en_rise_idle,
    input  logic       fall_sets_frame,
    input  logic [1:0] irq_en,
    output flags_t     flags,
    output logic       irq
);
    flags_t flags_q, flags_d;

    always_comb begin
        flags_d = flags_q;
        if (en_fall) begin
            flags_d.sync_err = 1'b0;
            if (fall_sets_frame)
                flags_d.frame_done = 1'b1;
        end
        if (en_rise_idle) begin
            flags_d.frame_done   = 1'b0;
            flags_d.palette_done = 1'b0;
        end
        // sequencer events take precedence over clearing side effects
        flags_d.frame_done   = flags_d.frame_done   | ev_frame_done;
        flags_d.palette_done = flags_d.palette_done | ev_palette_done;
        flags_d.sync_err     = flags_d.sync_err     | ev_sync_err;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    assign flags = flags_q;
    assign irq   = (flags_q.frame_done & irq_en[0])
                 | (flags_q.palette_done & irq_en[1])
                 | flags_q.sync_err;
endmodule

// File: rtl/lcd_read_mux.sv
module lcd_read_mux
    import lcd_reg_pkg::*;
#(
    parameter int DIM_W = 10
) (
    input  logic                    rd,
    input  reg_sel_e                sel,
    input  ctrl_t                   ctrl,
    input  logic [DATA_W-1:0]       tim0,
    input  logic [DATA_W-1:0]       tim1,
    input  logic [DATA_W-1:0]       tim2,
    input  logic [DATA_W-1:0]       sub,
    input  flags_t                  flags,
    output logic [DATA_W-1:0]       rdata
);
    always_comb begin
        rdata = '0;
        if (rd) begin
            case (sel)
                SEL_CTRL: rdata = ctrl_pack(ctrl) | CTRL_RD_ONES;
                SEL_TIM0: rdata = tim0 | TIM0_RD_ONES;
                SEL_TIM1: rdata = tim1;
                SEL_TIM2: rdata = tim2 | TIM2_RD_ONES;
                SEL_STAT: begin
                    rdata[STAT_FD_BIT] = flags.frame_done;
                    rdata[STAT_SE_BIT] = flags.sync_err;
                    rdata[STAT_PL_BIT] = flags.palette_done;
                end
                SEL_SUB:  rdata = sub;
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/lcd_reg_block.sv
module lcd_reg_block
    import lcd_reg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DIM_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bad_access,
    input  logic              ev_frame_done,
    input  logic              ev_palette_done,
    input  logic              ev_sync_err,
    input  logic              seq_idle,
    output logic              lcd_irq,
    output logic              cfg_enable,
    output logic              cfg_mono,
    output logic              cfg_active_matrix,
    output logic [1:0]        cfg_load_mode,
    output logic [DIM_W-1:0]  cfg_width_m1,
    output logic [DIM_W-1:0]  cfg_height_m1,
    output logic              cfg_sub_enable,
    output logic              cfg_sub_lower,
    output logic [DIM_W-1:0]  cfg_sub_line
);
    localparam int UP_W = DATA_W - DIM_W;

    reg_sel_e          sel;
    ctrl_t             ctrl_q, ctrl_new;
    logic [UP_W-1:0]   t0_hi, t1_hi;
    logic [DIM_W-1:0]  t0_dim, t1_dim;
    logic [DATA_W-1:0] t2_q, sub_q;
    logic              bad_q;
    flags_t            flags_q;
    logic              wr_ctrl, en_fall, en_rise_idle, fall_sets_frame;

    lcd_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign ctrl_new        = ctrl_unpack(bus_wdata);
    assign wr_ctrl         = bus_wr && (sel == SEL_CTRL);
    assign en_fall         = wr_ctrl && ctrl_q.enable && !ctrl_new.enable;
    assign en_rise_idle    = wr_ctrl && !ctrl_q.enable && ctrl_new.enable && seq_idle;
    assign fall_sets_frame = (ctrl_new.load_mode != LOAD_PALETTE_ONLY);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            t0_hi  <= '0;
            t0_dim <= '0;
            t1_hi  <= '0;
            t1_dim <= '0;
            t2_q   <= '0;
            sub_q  <= '0;
            bad_q  <= 1'b0;
        end else begin
            bad_q <= bus_rd && (sel == SEL_NONE);
            if (bus_wr) begin
                case (sel)
                    SEL_CTRL: ctrl_q <= ctrl_new;
                    SEL_TIM0: begin
                        t0_hi  <= bus_wdata[DATA_W-1:DIM_W];
                        t0_dim <= bus_wdata[DIM_W-1:0];
                    end
                    SEL_TIM1: begin
                        t1_hi  <= bus_wdata[DATA_W-1:DIM_W];
                        t1_dim <= bus_wdata[DIM_W-1:0];
                    end
                    SEL_TIM2: t2_q  <= bus_wdata;
                    SEL_SUB:  sub_q <= bus_wdata & SUB_KEEP_MASK;
                    default:  ;
                endcase
            end
        end
    end

    lcd_status_flags u_flags (
        .clk             (clk),
        .rst             (rst),
        .ev_frame_done   (ev_frame_done),
        .ev_palette_done (ev_palette_done),
        .ev_sync_err     (ev_sync_err),
        .en_fall         (en_fall),
        .en_rise_idle    (en_rise_idle),
        .fall_sets_frame (fall_sets_frame),
        .irq_en          (ctrl_q.irq_en),
        .flags           (flags_q),
        .irq             (lcd_irq)
    );

    lcd_read_mux #(.DIM_W(DIM_W)) u_rmux (
        .rd    (bus_rd),
        .sel   (sel),
        .ctrl  (ctrl_q),
        .tim0  ({t0_hi, t0_dim}),
        .tim1  ({t1_hi, t1_dim}),
        .tim2  (t2_q),
        .sub   (sub_q),
        .flags (flags_q),
        .rdata (bus_rdata)
    );

    assign bad_access        = bad_q;
    assign cfg_enable        = ctrl_q.enable;
    assign cfg_mono          = ctrl_q.mono;
    assign cfg_active_matrix = ctrl_q.active_matrix;
    assign cfg_load_mode     = ctrl_q.load_mode;
    assign cfg_width_m1      = t0_dim;
    assign cfg_height_m1     = t1_dim;
    assign cfg_sub_enable    = sub_q[SUB_EN_BIT];
    assign cfg_sub_lower     = sub_q[SUB_LOWER_BIT];
    assign cfg_sub_line      = sub_q[SUB_LINE_LSB +: DIM_W];
endmodule

// File: rtl/lcd_reg_block_chk.sv
module lcd_reg_block_chk
    import lcd_reg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DIM_W  = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bad_access,
    input logic              ev_frame_done,
    input logic              ev_palette_done,
    input logic              ev_sync_err,
    input logic              lcd_irq,
    input logic              cfg_enable,
    input logic [DIM_W-1:0]  cfg_width_m1,
    input flags_t            flags
);
    logic no_ev;
    assign no_ev = !ev_frame_done && !ev_palette_done && !ev_sync_err;

    // R8: a sync error raises the interrupt whatever the enables
    p_sync_irq_r8: assert property (@(posedge clk) disable iff (rst)
        ev_sync_err |=> lcd_irq);

    // R11: the bad-access pulse only follows a read
    p_bad_after_read_r11: assert property (@(posedge clk) disable iff (rst)
        bad_access |-> $past(bus_rd));

    // R5: writing the status offset leaves the flags alone
    p_status_write_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(8'h10) && no_ev) |=> $stable(flags));

    // R9: turning the controller off drops sync error
    p_disable_clears_sync_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(8'h00) && cfg_enable && !bus_wdata[0]
         && !ev_sync_err) |=> !flags.sync_err);

    // R12: exported width moves only on a timing-0 write
    p_width_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == ADDR_W'(8'h04)) |=> $stable(cfg_width_m1));
endmodule

bind lcd_reg_block lcd_reg_block_chk #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .bus_wr          (bus_wr),
    .bus_rd          (bus_rd),
    .bus_addr        (bus_addr),
    .bus_wdata       (bus_wdata),
    .bad_access      (bad_access),
    .ev_frame_done   (ev_frame_done),
    .ev_palette_done (ev_palette_done),
    .ev_sync_err     (ev_sync_err),
    .lcd_irq         (lcd_irq),
    .cfg_enable      (cfg_enable),
    .cfg_width_m1    (cfg_width_m1),
    .flags           (flags_q)
);

// File: tb/lcd_reg_block_tb.sv
module lcd_reg_block_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 0, bus_rd = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        bad_access, lcd_irq;
    logic        ev_f = 0, ev_p = 0, ev_s = 0, seq_idle = 1;
    logic        cfg_enable, cfg_mono, cfg_am, cfg_sub_enable, cfg_sub_lower;
    logic [1:0]  cfg_load_mode;
    logic [9:0]  cfg_width_m1, cfg_height_m1, cfg_sub_line;

    int    checks = 0, fails = 0;
    bit    done = 0;
    string focus = "";

    // behavioural reference state
    logic        m_en, m_mono, m_tft;
    logic [1:0]  m_ie, m_plm;
    logic [31:0] m_misc, m_t0, m_t1, m_t2, m_sub;
    logic        m_fd, m_pl, m_se, m_bad;

    always #(CLK_P/2) clk = ~clk;

    lcd_reg_block u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bad_access(bad_access), .ev_frame_done(ev_f), .ev_palette_done(ev_p),
        .ev_sync_err(ev_s), .seq_idle(seq_idle), .lcd_irq(lcd_irq),
        .cfg_enable(cfg_enable), .cfg_mono(cfg_mono), .cfg_active_matrix(cfg_am),
        .cfg_load_mode(cfg_load_mode), .cfg_width_m1(cfg_width_m1),
        .cfg_height_m1(cfg_height_m1), .cfg_sub_enable(cfg_sub_enable),
        .cfg_sub_lower(cfg_sub_lower), .cfg_sub_line(cfg_sub_line)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic bit mapped(input logic [7:0] a);
        return a == 8'h00 || a == 8'h04 || a == 8'h08 || a == 8'h0c || a == 8'h10 || a == 8'h14;
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h00: return ({31'd0, m_tft} << 23) | ({30'd0, m_plm} << 20) | ({31'd0, m_tft} << 7)
                        | ({30'd0, m_ie} << 3) | ({31'd0, m_mono} << 1) | {31'd0, m_en}
                        | m_misc | 32'hfe000c34;
            8'h04: return m_t0 | 32'h0000000f;
            8'h08: return m_t1;
            8'h0c: return m_t2 | 32'hfc000000;
            8'h10: return {25'd0, m_pl, 3'd0, m_se, 1'b0, m_fd};
            8'h14: return m_sub;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [7:0] a);
        if (focus != "") return focus;
        case (a)
            8'h00: return "R2";
            8'h04: return "R3";
            8'h08, 8'h0c: return "R4";
            8'h10: return "R7";
            8'h14: return "R6";
            default: return "R11";
        endcase
    endfunction

    task automatic compare();
        string t;
        t = (focus != "") ? focus : "R8";
        chk({t, " irq"}, {31'd0, lcd_irq}, {31'd0, (m_fd & m_ie[0]) | (m_pl & m_ie[1]) | m_se});
        t = (focus != "") ? focus : "R11";
        chk({t, " bad_access"}, {31'd0, bad_access}, {31'd0, m_bad});
        chk({rd_tag(bus_addr), " rdata"}, bus_rdata, bus_rd ? model_read(bus_addr) : 32'h0);
        t = (focus != "") ? focus : "R12";
        chk({t, " cfg ctrl"}, {27'd0, cfg_enable, cfg_mono, cfg_am, cfg_load_mode},
            {27'd0, m_en, m_mono, m_tft, m_plm});
        chk({t, " cfg size"}, {12'd0, cfg_width_m1, cfg_height_m1}, {12'd0, m_t0[9:0], m_t1[9:0]});
        chk({t, " cfg sub"}, {20'd0, cfg_sub_enable, cfg_sub_lower, cfg_sub_line},
            {20'd0, m_sub[31], m_sub[29], m_sub[25:16]});
    endtask

    task automatic model_step();
        logic nfd, npl, nse;
        if (rst) begin
            {m_en, m_mono, m_tft, m_ie, m_plm} = '0;
            {m_misc, m_t0, m_t1, m_t2, m_sub} = '0;
            {m_fd, m_pl, m_se, m_bad} = '0;
            return;
        end
        nfd = m_fd; npl = m_pl; nse = m_se;
        if (bus_wr && bus_addr == 8'h00) begin
            if (m_en && !bus_wdata[0]) begin
                nse = 0;
                if (bus_wdata[21:20] != 2'd1) nfd = 1;
            end
            if (!m_en && bus_wdata[0] && seq_idle) begin
                nfd = 0; npl = 0;
            end
        end
        m_fd = nfd | ev_f; m_pl = npl | ev_p; m_se = nse | ev_s;
        m_bad = bus_rd && !mapped(bus_addr);
        if (bus_wr) begin
            case (bus_addr)
                8'h00: begin
                    m_en = bus_wdata[0]; m_mono = bus_wdata[1]; m_ie = bus_wdata[4:3];
                    m_tft = bus_wdata[7]; m_plm = bus_wdata[21:20];
                    m_misc = bus_wdata & 32'h01cff300;
                end
                8'h04: m_t0 = bus_wdata;
                8'h08: m_t1 = bus_wdata;
                8'h0c: m_t2 = bus_wdata;
                8'h14: m_sub = bus_wdata & 32'ha1ffffff;
                default: ;
            endcase
        end
    endtask

    task automatic cyc(input logic w, input logic r, input logic [7:0] a, input logic [31:0] d,
                       input logic f, input logic p, input logic s);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
        ev_f = f; ev_p = p; ev_s = s;
        #(CLK_P/4);
        compare();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d); cyc(1, 0, a, d, 0, 0, 0); endtask
    task automatic rd(input logic [7:0] a);                      cyc(0, 1, a, 0, 0, 0, 0); endtask
    task automatic ev(input logic f, input logic p, input logic s); cyc(0, 0, 0, 0, f, p, s); endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst = 1;
        cyc(0, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        rst = 0;
        // R1: reset values
        focus = "R1";
        for (int i = 0; i < 6; i++) rd(8'(i * 4));
        focus = "";

        // R3, R4, R6, R12: timing and sub-panel
        wr(8'h04, 32'hdeadb27f); rd(8'h04);
        wr(8'h08, 32'h12345abc); rd(8'h08);
        wr(8'h0c, 32'h000000a5); rd(8'h0c);
        wr(8'h14, 32'hffffffff); rd(8'h14);
        wr(8'h14, 32'h5a5a5a5a); rd(8'h14);
        // R2: control masking with enable left off
        wr(8'h00, 32'hfffffffe); rd(8'h00);
        wr(8'h00, 32'h00000000); rd(8'h00);

        // R7, R8: events with both interrupt enables
        wr(8'h00, 32'h00000018);
        ev(1, 0, 0); rd(8'h10);
        // R10: enable while idle clears frame-done and palette-loaded
        focus = "R10";
        ev(0, 1, 0);
        wr(8'h00, 32'h00000019); rd(8'h10);
        focus = "";
        ev(0, 1, 1); rd(8'h10);
        // R9: disable clears sync error and sets frame-done
        focus = "R9";
        seq_idle = 0;
        wr(8'h00, 32'h00000018); rd(8'h10);
        focus = "R10";
        wr(8'h00, 32'h00000019); rd(8'h10);
        seq_idle = 1;
        wr(8'h00, 32'h00000018);
        wr(8'h00, 32'h00000019); rd(8'h10);
        // R9: palette-only mode does not set frame-done
        focus = "R9";
        wr(8'h00, 32'h00100018); rd(8'h10);
        // R7: event beats the clear in the same cycle
        focus = "R7";
        wr(8'h00, 32'h00000019);
        cyc(1, 0, 8'h00, 32'h00000000, 0, 0, 1); rd(8'h10);
        // R8: sync error interrupts with enables off
        focus = "R8";
        wr(8'h00, 32'h00000000); rd(8'h10);
        // R5: status writes ignored
        focus = "R5";
        wr(8'h00, 32'h00000001);
        ev(1, 1, 0);
        wr(8'h10, 32'hffffffff); rd(8'h10);
        wr(8'h10, 32'h00000000); rd(8'h10);
        // R11: unmapped accesses
        focus = "R11";
        rd(8'h18); rd(8'h02); rd(8'hfc);
        wr(8'h18, 32'hffffffff); wr(8'h01, 32'hffffffff); wr(8'h13, 32'hffffffff);
        for (int i = 0; i < 6; i++) rd(8'(i * 4));
        focus = "";

        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [7:0] a;
            logic [31:0] d;
            int k;
            k = int'($urandom_range(0, 7));
            a = (k < 6) ? 8'(k * 4) : 8'($urandom_range(0, 255));
            d = $urandom;
            seq_idle = ($urandom_range(0, 3) != 0);
            cyc($urandom_range(0, 2) == 0, $urandom_range(0, 1) == 0, a, d,
                $urandom_range(0, 5) == 0, $urandom_range(0, 5) == 0, $urandom_range(0, 9) == 0);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule